// File: doc/BRIEF.md
# PRBS Receive Checker with Link and Error-Window Monitor

This block sits behind the parallel receive path of a serial transceiver and grades the incoming bit stream against a pseudo-random binary sequence of a selectable order. It holds no seed. Each received bit is predicted from the bits that came before it, using the recurrence of the selected polynomial. The checker therefore locks onto any phase of the incoming sequence by itself, once enough history has arrived. Each mismatch between a received bit and its prediction counts as one bit error.

Two figures come out of the block. The first is a link flag. It rises once an unbroken run of error-free checked bits reaches a parameterised length (100 bits by default), and it falls on any error. The second is a pair of counters, errored bits and checked bits, held over a fixed window of clock cycles (one second at the default clock). Both counters are presented together with a one-cycle update strobe. A software or display layer divides the two to obtain the error ratio. A polarity-invert control compensates for a swapped differential pair.

Top module: `prbs_rx_monitor`

## Requirements
- R1: `order_sel` encodes the polynomial: 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^23+x^18+1, 3 = x^31+x^28+1. Bit `rx_data[DW-1]` is the oldest bit of a word and bit 0 is the newest. A bit is in error when it differs from the XOR of the received bits that came `far` and `near` positions before it, where (far, near) are the two exponents of the selected polynomial.
- R2: The error contribution of a checked word is the number of its erroneous bits. Its bit contribution is DW.
- R3: When `rx_invert` is 1, every data bit is complemented before it is checked and before it enters the history.
- R4: After reset, and after a change of order, the first ceil(31/DW) valid words only fill the history. They add nothing to the link run or to the window counts.
- R5: Link is counted per word. Each clean checked word adds DW good bits, capped at LINK_BITS. `link_up` is 1 once the count reaches LINK_BITS. `link_up` changes two cycles after the word that completes the run is presented.
- R6: A checked word with at least one error clears the good-bit run, and `link_up` is 0 two cycles after that word.
- R7: A word presented in the same cycle that `order_sel` changes is discarded. The change also clears the good-bit run, and `link_up` is 0 two cycles later.
- R8: Every WIN_CYCLES clock cycles after reset, `win_errors` and `win_bits` load the totals of the window just ended, and `win_update` is 1 for exactly one cycle.
- R9: The window accumulators restart from zero after each load.
- R10: The window accumulators and the loaded values saturate at 2^CNT_W-1 and never wrap.
- R11: Synchronous active-high `rst` clears the history, the link flag, the window counter, the accumulators and all outputs.
- R12: Cycles with `rx_valid` at 0 change neither the history nor any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | DW | Received parallel word, oldest bit at the MSB |
| rx_valid | input | 1 | Word qualifier |
| order_sel | input | 2 | Polynomial select |
| rx_invert | input | 1 | Complement received bits |
| link_up | output | 1 | Error-free run has reached LINK_BITS |
| win_errors | output | CNT_W | Errored bits in the last window |
| win_bits | output | CNT_W | Checked bits in the last window |
| win_update | output | 1 | One-cycle pulse when the window values load |

## Verification
The assertions check, on every cycle, that an errored checked word or an order restart always leaves the link flag low on the next cycle. They also check that the link flag only rises after a clean word, that the update strobe lasts one cycle and recurs exactly every WIN_CYCLES cycles, that a saturated accumulator stays saturated within its window, and that each loaded bit count is a whole number of words or the saturation value. Only the bench's scenarios can show the rest: the exact error counts for a given polynomial and bit order, the 100-bit threshold falling on the right word, the priming words after a restart, polarity inversion, and the fact that gaps in the valid signal are ignored. The bench covers these by running a serial bit-by-bit model next to the design and by adding directed boundary checks.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  localparam int HIST_W = 31;

  typedef struct packed {
    logic [4:0] far;
    logic [4:0] near;
  } tap_pair_t;

  function automatic tap_pair_t taps_of(input logic [1:0] ord);
    tap_pair_t t;
    case (ord)
      2'd0:    begin t.far = 5'd7;  t.near = 5'd6;  end
      2'd1:    begin t.far = 5'd15; t.near = 5'd14; end
      2'd2:    begin t.far = 5'd23; t.near = 5'd18; end
      default: begin t.far = 5'd31; t.near = 5'd28; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/prbs_selfsync_check.sv
module prbs_selfsync_check
  import prbs_mon_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ERR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    din,
  input  logic             din_vld,
  input  logic [1:0]       order,
  input  logic             invert,
  output logic             s1_vld,
  output logic [ERR_W-1:0] s1_err,
  output logic             s1_restart
);

  localparam int EXT_W       = DW + HIST_W;
  localparam int PRIME_WORDS = (HIST_W + DW - 1) / DW;
  localparam int PRIME_W     = $clog2(PRIME_WORDS + 1);

  logic [HIST_W-1:0]  hist_q;
  logic [1:0]         order_q;
  logic [PRIME_W-1:0] prime_q;
  logic [DW-1:0]      rx_bits, pred, mism;
  logic [EXT_W-1:0]   ext, sh_far, sh_near;
  tap_pair_t          tp;
  logic [ERR_W-1:0]   n_err;
  logic               restart;

  // prediction: bit i is checked against the bits far/near places older
  always_comb begin
    rx_bits = din ^ {DW{invert}};
    ext     = {hist_q, rx_bits};
    tp      = taps_of(order);
    sh_far  = ext >> tp.far;
    sh_near = ext >> tp.near;
    pred    = sh_far[DW-1:0] ^ sh_near[DW-1:0];
    mism    = rx_bits ^ pred;
    n_err   = '0;
    for (int i = 0; i < DW; i++) n_err = n_err + ERR_W'(mism[i]);
    restart = (order != order_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q     <= '0;
      order_q    <= order;
      prime_q    <= '0;
      s1_vld     <= 1'b0;
      s1_err     <= '0;
      s1_restart <= 1'b0;
    end else begin
      order_q    <= order;
      s1_restart <= restart;
      if (restart) begin
        prime_q <= '0;
        s1_vld  <= 1'b0;
      end else if (din_vld) begin
        hist_q <= ext[HIST_W-1:0];
        if (prime_q < PRIME_W'(PRIME_WORDS)) begin
          prime_q <= prime_q + 1'b1;
          s1_vld  <= 1'b0;
        end else begin
          s1_vld <= 1'b1;
          s1_err <= n_err;
        end
      end else begin
        s1_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prbs_link_track.sv
module prbs_link_track #(
  parameter int DW        = 16,
  parameter int ERR_W     = 5,
  parameter int LINK_BITS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_vld,
  input  logic [ERR_W-1:0] s1_err,
  input  logic             s1_restart,
  output logic             link
);

  localparam int GOOD_W = $clog2(LINK_BITS + 1);

  logic [GOOD_W-1:0] good_q;
  logic [GOOD_W:0]   sum;
  logic [GOOD_W-1:0] good_nxt;

  always_comb begin
    sum = {1'b0, good_q} + (GOOD_W+1)'(DW);
    if (sum >= (GOOD_W+1)'(LINK_BITS)) good_nxt = GOOD_W'(LINK_BITS);
    else                               good_nxt = sum[GOOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || s1_restart) begin
      good_q <= '0;
      link   <= 1'b0;
    end else if (s1_vld) begin
      if (s1_err != '0) begin
        good_q <= '0;
        link   <= 1'b0;
      end else begin
        good_q <= good_nxt;
        link   <= (good_nxt == GOOD_W'(LINK_BITS));
      end
    end
  end

endmodule

// File: rtl/prbs_ber_window.sv
module prbs_ber_window #(
  parameter int DW         = 16,
  parameter int ERR_W      = 5,
  parameter int CNT_W      = 32,
  parameter int WIN_CYCLES = 200_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_vld,
  input  logic [ERR_W-1:0] s1_err,
  output logic [CNT_W-1:0] out_err,
  output logic [CNT_W-1:0] out_bits,
  output logic             out_upd,
  output logic [CNT_W-1:0] acc_bits,
  output logic             win_end
);

  localparam int WIN_W = $clog2(WIN_CYCLES);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] acc_err_q, acc_bits_q, inc_err, inc_bits, nxt_err, nxt_bits;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_comb begin
    win_end  = (win_q == WIN_W'(WIN_CYCLES - 1));
    inc_err  = s1_vld ? CNT_W'(s1_err) : '0;
    inc_bits = s1_vld ? CNT_W'(DW) : '0;
    nxt_err  = sat_add(acc_err_q, inc_err);
    nxt_bits = sat_add(acc_bits_q, inc_bits);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= '0;
      acc_err_q  <= '0;
      acc_bits_q <= '0;
      out_err    <= '0;
      out_bits   <= '0;
      out_upd    <= 1'b0;
    end else if (win_end) begin
      win_q      <= '0;
      out_err    <= nxt_err;
      out_bits   <= nxt_bits;
      acc_err_q  <= '0;
      acc_bits_q <= '0;
      out_upd    <= 1'b1;
    end else begin
      win_q      <= win_q + 1'b1;
      acc_err_q  <= nxt_err;
      acc_bits_q <= nxt_bits;
      out_upd    <= 1'b0;
    end
  end

  assign acc_bits = acc_bits_q;

endmodule

// File: rtl/prbs_rx_monitor.sv
module prbs_rx_monitor #(
  parameter int DW         = 16,
  parameter int LINK_BITS  = 100,
  parameter int CNT_W      = 32,
  parameter int WIN_CYCLES = 200_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_valid,
  input  logic [1:0]       order_sel,
  input  logic             rx_invert,
  output logic             link_up,
  output logic [CNT_W-1:0] win_errors,
  output logic [CNT_W-1:0] win_bits,
  output logic             win_update
);

  localparam int ERR_W = $clog2(DW + 1);

  logic             s1_vld, s1_restart, win_end;
  logic [ERR_W-1:0] s1_err;
  logic [CNT_W-1:0] acc_bits;

  prbs_selfsync_check #(.DW(DW), .ERR_W(ERR_W)) u_check (
    .clk(clk), .rst(rst), .din(rx_data), .din_vld(rx_valid),
    .order(order_sel), .invert(rx_invert),
    .s1_vld(s1_vld), .s1_err(s1_err), .s1_restart(s1_restart)
  );

  prbs_link_track #(.DW(DW), .ERR_W(ERR_W), .LINK_BITS(LINK_BITS)) u_link (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_err(s1_err),
    .s1_restart(s1_restart), .link(link_up)
  );

  prbs_ber_window #(.DW(DW), .ERR_W(ERR_W), .CNT_W(CNT_W),
                    .WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_err(s1_err),
    .out_err(win_errors), .out_bits(win_bits), .out_upd(win_update),
    .acc_bits(acc_bits), .win_end(win_end)
  );

endmodule

// File: rtl/prbs_rx_monitor_chk.sv
module prbs_rx_monitor_chk #(
  parameter int DW         = 16,
  parameter int CNT_W      = 32,
  parameter int ERR_W      = 5,
  parameter int WIN_CYCLES = 200_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic             link_up,
  input logic             win_update,
  input logic [CNT_W-1:0] win_bits,
  input logic             s1_vld,
  input logic [ERR_W-1:0] s1_err,
  input logic             s1_restart,
  input logic [CNT_W-1:0] acc_bits,
  input logic             win_end
);

  localparam int CC_W = $clog2(WIN_CYCLES + 1);
  logic [CC_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst)             cyc_q <= '0;
    else if (win_update) cyc_q <= CC_W'(1);
    else                 cyc_q <= cyc_q + 1'b1;
  end

  p_err_drops_link_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_err != '0) |=> !link_up);

  p_restart_drops_link_r7: assert property (@(posedge clk) disable iff (rst)
    s1_restart |=> !link_up);

  p_link_after_clean_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(s1_vld && s1_err == '0));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    win_update |=> !win_update);

  p_strobe_period_r8: assert property (@(posedge clk) disable iff (rst)
    win_update |-> (cyc_q == CC_W'(WIN_CYCLES)));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_bits == '1 && !win_end) |=> acc_bits == '1);

  p_bits_whole_r2: assert property (@(posedge clk) disable iff (rst)
    win_update |-> ((win_bits % CNT_W'(DW)) == '0 || win_bits == '1));

endmodule

bind prbs_rx_monitor prbs_rx_monitor_chk #(
  .DW(DW), .CNT_W(CNT_W), .ERR_W(ERR_W), .WIN_CYCLES(WIN_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .link_up(link_up), .win_update(win_update),
  .win_bits(win_bits), .s1_vld(s1_vld), .s1_err(s1_err),
  .s1_restart(s1_restart), .acc_bits(acc_bits), .win_end(win_end)
);

// File: tb/sim_prbs_rx_monitor.sv
`timescale 1ns/1ps
module sim_prbs_rx_monitor;

  localparam int DW    = 16;
  localparam int LINKB = 100;
  localparam int CW    = 8;
  localparam int WIN   = 40;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] rx_data = '0;
  logic          rx_valid = 1'b0;
  logic [1:0]    order_sel = 2'd0;
  logic          rx_invert = 1'b0;
  logic          link_up, win_update;
  logic [CW-1:0] win_errors, win_bits;

  int tests = 0, fails = 0;
  string tag = "R11";
  bit sat_seen = 0;

  always #2.5 clk = ~clk;

  prbs_rx_monitor #(.DW(DW), .LINK_BITS(LINKB), .CNT_W(CW), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .order_sel(order_sel), .rx_invert(rx_invert), .link_up(link_up),
    .win_errors(win_errors), .win_bits(win_bits), .win_update(win_update)
  );

  function automatic int tfar(input logic [1:0] o);
    return (o == 0) ? 7 : (o == 1) ? 15 : (o == 2) ? 23 : 31;
  endfunction
  function automatic int tnear(input logic [1:0] o);
    return (o == 0) ? 6 : (o == 1) ? 14 : (o == 2) ? 18 : 28;
  endfunction

  // serial reference: walk the word oldest bit first
  function automatic int count_errs(input logic [63:0] h, input logic [DW-1:0] w,
                                    input logic [1:0] o);
    int c = 0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (w[i] != (h[tfar(o)-1] ^ h[tnear(o)-1])) c++;
      h = {h[62:0], w[i]};
    end
    return c;
  endfunction

  function automatic int sat(input int a, input int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  // reference model, updated on the same edges as the design
  int m_win, m_acce, m_accb, m_oute, m_outb, m_good, m_s1e, m_prime;
  bit m_upd, m_link, m_s1v, m_s1r;
  logic [1:0]  m_ordq;
  logic [63:0] m_hist;

  always @(posedge clk) begin
    if (rst) begin
      m_win = 0; m_acce = 0; m_accb = 0; m_oute = 0; m_outb = 0; m_upd = 0;
      m_good = 0; m_link = 0; m_s1v = 0; m_s1r = 0; m_s1e = 0; m_prime = 0;
      m_ordq = order_sel; m_hist = '0;
    end else begin
      int ie, ib, e;
      logic [DW-1:0] w;
      bit rs;
      ie = m_s1v ? m_s1e : 0;
      ib = m_s1v ? DW : 0;
      if (m_win == WIN - 1) begin
        m_oute = sat(m_acce, ie); m_outb = sat(m_accb, ib);
        m_acce = 0; m_accb = 0; m_upd = 1; m_win = 0;
      end else begin
        m_acce = sat(m_acce, ie); m_accb = sat(m_accb, ib); m_upd = 0; m_win++;
      end
      if (m_s1r) begin m_good = 0; m_link = 0; end
      else if (m_s1v) begin
        if (m_s1e != 0) begin m_good = 0; m_link = 0; end
        else begin
          m_good = (m_good + DW > LINKB) ? LINKB : m_good + DW;
          m_link = (m_good >= LINKB);
        end
      end
      rs = (order_sel != m_ordq);
      m_ordq = order_sel;
      m_s1r = rs;
      if (rs) begin m_prime = 0; m_s1v = 0; end
      else if (rx_valid) begin
        w = rx_data ^ {DW{rx_invert}};
        e = count_errs(m_hist, w, order_sel);
        m_hist = (m_hist << DW) | 64'(w);
        if (m_prime < 2) begin m_prime++; m_s1v = 0; end
        else begin m_s1v = 1; m_s1e = e; end
      end else m_s1v = 0;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic compare_all();
    check({tag, " link"}, int'(link_up), int'(m_link));
    check({tag, " R8 R9 errors"}, int'(win_errors), m_oute);
    check({tag, " R8 R9 bits"}, int'(win_bits), m_outb);
    check({tag, " R8 strobe"}, int'(win_update), int'(m_upd));
    if (win_update && win_bits == CMAX) sat_seen = 1;
  endtask

  // stimulus generator
  logic [63:0] gh;
  function automatic logic [DW-1:0] next_word(input logic [1:0] o);
    logic [DW-1:0] w;
    logic b;
    for (int i = DW - 1; i >= 0; i--) begin
      b = gh[tfar(o)-1] ^ gh[tnear(o)-1];
      w[i] = b;
      gh = {gh[62:0], b};
    end
    return w;
  endfunction

  task automatic step(input logic [DW-1:0] d, input logic v,
                      input logic [1:0] o, input logic inv);
    @(negedge clk);
    compare_all();
    rx_data = d; rx_valid = v; order_sel = o; rx_invert = inv;
  endtask

  task automatic send(input logic [1:0] o, input logic inv, input logic [DW-1:0] emask);
    step(next_word(o) ^ {DW{inv}} ^ emask, 1'b1, o, inv);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(DW'($urandom), 1'b0, order_sel, rx_invert);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    gh = 64'hACE1_2468_1357_BDF9;
    repeat (4) @(negedge clk);
    tag = "R11";
    check("R11 reset link", int'(link_up), 0);
    check("R11 reset bits", int'(win_bits), 0);
    check("R11 reset strobe", int'(win_update), 0);
    rst = 1'b0;

    // R4 + R5: two priming words, then 6 words = 96 bits, then the 100-bit word
    tag = "R5";
    for (int i = 0; i < 8; i++) send(2'd0, 1'b0, '0);
    idle(2);
    check("R4 R5 link low at 96 bits", int'(link_up), 0);
    send(2'd0, 1'b0, '0);
    idle(1);
    check("R5 link not yet", int'(link_up), 0);
    idle(1);
    check("R5 link high at 112 bits", int'(link_up), 1);

    // R12: gaps with garbage leave link and history alone
    tag = "R12";
    idle(5);
    send(2'd0, 1'b0, '0);
    idle(2);
    check("R12 gaps ignored", int'(link_up), 1);

    // R6: single bit error
    tag = "R6";
    send(2'd0, 1'b0, 16'h0100);
    idle(2);
    check("R6 error drops link", int'(link_up), 0);
    for (int i = 0; i < 10; i++) send(2'd0, 1'b0, '0);

    // R7: order change
    tag = "R7";
    idle(2);
    check("R7 link before change", int'(link_up), 1);
    send(2'd3, 1'b0, '0);
    idle(2);
    check("R7 order change drops link", int'(link_up), 0);

    // R3: inverted polarity, R1 on each order
    tag = "R3 R1";
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 12; i++) send(2'(o), 1'b1, '0);
      idle(2);
      check("R3 R1 clean inverted stream links", int'(link_up), 1);
    end

    // R10: dense valid through a whole window
    tag = "R10";
    for (int i = 0; i < 3 * WIN; i++) send(2'd1, 1'b0, DW'($urandom) & DW'($urandom));

    // R11: mid-run reset
    tag = "R11";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 mid reset link", int'(link_up), 0);
    check("R11 mid reset errors", int'(win_errors), 0);
    rst = 1'b0;

    // R1 R2: mixed random traffic
    tag = "R1 R2 R4 R12";
    for (int i = 0; i < 2500; i++) begin
      logic [1:0] o;
      logic inv;
      logic [DW-1:0] em;
      o = order_sel; inv = rx_invert;
      if ($urandom_range(99) == 0) o = 2'($urandom);
      if ($urandom_range(199) == 0) inv = ~inv;
      em = ($urandom_range(9) == 0) ? DW'(1) << $urandom_range(DW - 1) : '0;
      if ($urandom_range(3) == 0) step(DW'($urandom), 1'b0, o, inv);
      else send(o, inv, em);
    end
    idle(2 * WIN);
    check("R10 saturation seen", int'(sat_seen), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule